// File: doc/BRIEF.md
# Completion-Queue Pin Interrupt Aggregator

This block drives the single level-sensitive legacy interrupt pin of a storage controller that services many completion queues. Each completion queue owns one pending bit in a 64-entry vector. A completion posted to a queue whose interrupts are enabled sets that queue's bit. A head doorbell that drains the queue, meaning the new head equals the tail, clears it. A 32-bit shared mask lets the host silence queues 0 to 31. Queues 32 to 63 cannot be masked.

The mask is changed through two register offsets. Writing the set-mask offset ORs the written value into the mask. Writing the clear-mask offset removes the bits that are one in the written value. Both offsets read back the current mask.

The pin is a registered level. It is high exactly when some pending bit is left unmasked, and it follows every pending or mask change on the next clock edge. While message-signalled interrupts are enabled, the block freezes: events do not change the pending vector, mask writes are dropped, and the pin holds its level.

Top module: `cq_pin_irq`

## Requirements
- R1: After reset, irq_o is 0 and the mask reads back as 0 at both mask offsets.
- R2: With msix_en_i low, a post (post_valid_i=1, post_ien_i=1, post_qid_i<64) sets that queue's pending bit. If the bit is unmasked, irq_o becomes 1.
- R3: A post with post_ien_i=0 leaves the pending vector unchanged.
- R4: A post or doorbell whose queue id is 64 or greater is ignored.
- R5: A doorbell (db_valid_i=1, db_ien_i=1) with db_head_i equal to db_tail_i clears that queue's pending bit. A doorbell with head not equal to tail clears nothing.
- R6: A doorbell with db_ien_i=0 clears nothing.
- R7: A write to offset 0x0C ORs reg_wdata_i into the mask. A write to offset 0x10 clears the mask bits where reg_wdata_i is 1. Mask bit i covers queue i for i in 0..31, and irq_o is recomputed after each write.
- R8: reg_rdata_o returns the mask when reg_addr_i is 0x0C or 0x10, and returns 0 for any other offset.
- R9: Pending bits of queues 32..63 always drive irq_o, whatever the mask holds.
- R10: While msix_en_i is 1, posts, doorbells and mask writes have no effect, and irq_o holds its level.
- R11: If a post and a draining doorbell hit the same queue in the same cycle, the post wins and the bit ends set.
- R12: irq_o is registered. It changes on the clock edge that samples the causing input, and never combinationally before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msix_en_i | input | 1 | Message-signalled interrupts enabled; freezes the block |
| post_valid_i | input | 1 | Completion posted this cycle |
| post_qid_i | input | 7 | Queue id of the posted completion |
| post_ien_i | input | 1 | Interrupt enable of the posting queue |
| db_valid_i | input | 1 | Completion-queue head doorbell write this cycle |
| db_qid_i | input | 7 | Queue id of the doorbell |
| db_ien_i | input | 1 | Interrupt enable of the doorbell's queue |
| db_head_i | input | 16 | Head pointer after the doorbell |
| db_tail_i | input | 16 | Current tail pointer of that queue |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset, used for both write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Legacy interrupt pin level |

## Verification
The hardest situations to reach from the ports are two collisions. One is a post and a draining doorbell landing on the same queue in the same cycle. The other is a queue in the unmaskable upper range staying pending while the mask is fully set. Both are hit by directed steps. The random phase then draws queue ids from a range that overlaps the upper half and the illegal ids above 63, and it gives the doorbell the post's queue id a quarter of the time. It also makes head equal tail half the time and keeps the enable switched on for short random stretches. This mix makes collisions, freezes and mask edits happen against a pending vector that has many bits set.

// File: rtl/cq_pin_irq_pkg.sv
package cq_pin_irq_pkg;
  localparam int unsigned NUM_Q    = 64;
  localparam int unsigned QID_W    = 7;
  localparam int unsigned MASK_W   = 32;
  localparam int unsigned PTR_W    = 16;
  localparam int unsigned ADDR_W   = 5;
  localparam logic [ADDR_W-1:0] OFF_MSET = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_MCLR = 5'h10;
endpackage

// File: rtl/cq_pend_vec.sv
module cq_pend_vec #(
  parameter int unsigned NUM_Q = 64,
  parameter int unsigned QID_W = 7,
  parameter int unsigned PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msix_en_i,
  input  logic             post_valid_i,
  input  logic [QID_W-1:0] post_qid_i,
  input  logic             post_ien_i,
  input  logic             db_valid_i,
  input  logic [QID_W-1:0] db_qid_i,
  input  logic             db_ien_i,
  input  logic [PTR_W-1:0] db_head_i,
  input  logic [PTR_W-1:0] db_tail_i,
  output logic [NUM_Q-1:0] pend_d_o,
  output logic [NUM_Q-1:0] pend_q_o
);
  localparam int unsigned IDX_W = $clog2(NUM_Q);

  logic [NUM_Q-1:0] set_vec, clr_vec, pend_q;
  logic post_ok, drain_ok;

  assign post_ok  = post_valid_i && post_ien_i && !msix_en_i;
  assign drain_ok = db_valid_i && db_ien_i && !msix_en_i && (db_head_i == db_tail_i);

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    // ids >= NUM_Q match no bit and are dropped
    assign set_vec[g] = post_ok  && (post_qid_i == QID_W'(g));
    assign clr_vec[g] = drain_ok && (db_qid_i   == QID_W'(g));
  end

  // set after clear: a fresh completion beats a same-cycle drain
  assign pend_d_o = (pend_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d_o;
  end
  assign pend_q_o = pend_q;

  a_r2_post_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_valid_i && post_ien_i && !msix_en_i && (post_qid_i < QID_W'(NUM_Q)))
    |=> pend_q[$past(post_qid_i[IDX_W-1:0])]);

  a_r3_disabled_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_valid_i && !post_ien_i && !db_valid_i) |=> $stable(pend_q));

  a_r4_bad_qid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_valid_i && (post_qid_i >= QID_W'(NUM_Q)) && !db_valid_i) |=> $stable(pend_q));

  a_r5_drain_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_valid_i && db_ien_i && !msix_en_i && (db_head_i == db_tail_i)
     && (db_qid_i < QID_W'(NUM_Q)) && !(post_valid_i && post_ien_i && post_qid_i == db_qid_i))
    |=> !pend_q[$past(db_qid_i[IDX_W-1:0])]);

  a_r10_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msix_en_i |=> $stable(pend_q));
endmodule

// File: rtl/cq_mask_reg.sv
module cq_mask_reg
  import cq_pin_irq_pkg::*;
#(
  parameter int unsigned MASK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msix_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [MASK_W-1:0] reg_wdata_i,
  output logic [MASK_W-1:0] reg_rdata_o,
  output logic [MASK_W-1:0] mask_d_o,
  output logic [MASK_W-1:0] mask_q_o
);
  logic [MASK_W-1:0] mask_q;
  logic hit_set, hit_clr;

  assign hit_set = reg_addr_i == OFF_MSET;
  assign hit_clr = reg_addr_i == OFF_MCLR;

  always_comb begin
    mask_d_o = mask_q;
    if (reg_we_i && !msix_en_i) begin
      if (hit_set)      mask_d_o = mask_q | reg_wdata_i;
      else if (hit_clr) mask_d_o = mask_q & ~reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d_o;
  end

  assign mask_q_o    = mask_q;
  assign reg_rdata_o = (hit_set || hit_clr) ? mask_q : '0;

  a_r7_set_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && hit_set && !msix_en_i) |=> ((mask_q & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  a_r7_clr_and: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && hit_clr && !msix_en_i) |=> ((mask_q & $past(reg_wdata_i)) == '0));

  a_r10_mask_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msix_en_i |=> $stable(mask_q));
endmodule

// File: rtl/cq_pin_drv.sv
module cq_pin_drv #(
  parameter int unsigned NUM_Q  = 64,
  parameter int unsigned MASK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msix_en_i,
  input  logic [NUM_Q-1:0]  pend_d_i,
  input  logic [MASK_W-1:0] mask_d_i,
  output logic              irq_o
);
  localparam int unsigned HI_W = NUM_Q - MASK_W;

  logic [NUM_Q-1:0] mask_ext;
  logic irq_q;

  // upper queues are never masked
  assign mask_ext = {{HI_W{1'b0}}, mask_d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         irq_q <= 1'b0;
    else if (!msix_en_i) irq_q <= |(pend_d_i & ~mask_ext);
  end
  assign irq_o = irq_q;

  a_r10_pin_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msix_en_i |=> $stable(irq_q));
endmodule

// File: rtl/cq_pin_irq.sv
module cq_pin_irq
  import cq_pin_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msix_en_i,
  input  logic              post_valid_i,
  input  logic [QID_W-1:0]  post_qid_i,
  input  logic              post_ien_i,
  input  logic              db_valid_i,
  input  logic [QID_W-1:0]  db_qid_i,
  input  logic              db_ien_i,
  input  logic [PTR_W-1:0]  db_head_i,
  input  logic [PTR_W-1:0]  db_tail_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [MASK_W-1:0] reg_wdata_i,
  output logic [MASK_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_Q-1:0]  pend_d, pend_q;
  logic [MASK_W-1:0] mask_d, mask_q;

  cq_pend_vec #(.NUM_Q(NUM_Q), .QID_W(QID_W), .PTR_W(PTR_W)) u_pend (
    .clk_i, .rst_ni, .msix_en_i,
    .post_valid_i, .post_qid_i, .post_ien_i,
    .db_valid_i, .db_qid_i, .db_ien_i, .db_head_i, .db_tail_i,
    .pend_d_o(pend_d), .pend_q_o(pend_q)
  );

  cq_mask_reg #(.MASK_W(MASK_W)) u_mask (
    .clk_i, .rst_ni, .msix_en_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .mask_d_o(mask_d), .mask_q_o(mask_q)
  );

  cq_pin_drv #(.NUM_Q(NUM_Q), .MASK_W(MASK_W)) u_pin (
    .clk_i, .rst_ni, .msix_en_i,
    .pend_d_i(pend_d), .mask_d_i(mask_d), .irq_o
  );

  a_r12_pin_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msix_en_i |=> (irq_o == |(pend_q & ~{{(NUM_Q-MASK_W){1'b0}}, mask_q})));

  a_r9_upper_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msix_en_i |=> ((|pend_q[NUM_Q-1:MASK_W]) -> irq_o));
endmodule

// File: tb/cq_pin_irq_bench.sv
module cq_pin_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msix_en = 0, post_v = 0, post_ien = 0, db_v = 0, db_ien = 0, we = 0;
  logic [6:0]  post_qid = '0, db_qid = '0;
  logic [15:0] head = '0, tail = '0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [63:0] m_pend = '0;
  logic [31:0] m_mask = '0;
  logic        m_irq = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  cq_pin_irq u_cq_pin_irq (
    .clk_i(clk), .rst_ni(rst_n), .msix_en_i(msix_en),
    .post_valid_i(post_v), .post_qid_i(post_qid), .post_ien_i(post_ien),
    .db_valid_i(db_v), .db_qid_i(db_qid), .db_ien_i(db_ien),
    .db_head_i(head), .db_tail_i(tail),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic exp_irq(logic [63:0] p, logic [31:0] m);
    logic r = 1'b0;
    for (int i = 0; i < 64; i++)
      if (p[i] && (i >= 32 || !m[i])) r = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    post_v = 0; db_v = 0; we = 0; post_ien = 0; db_ien = 0;
  endtask

  // model the edge, then sample on the falling edge
  task automatic cyc();
    @(posedge clk);
    if (!msix_en) begin
      if (db_v && db_ien && head == tail && db_qid < 64) m_pend[db_qid[5:0]] = 1'b0;
      if (post_v && post_ien && post_qid < 64) m_pend[post_qid[5:0]] = 1'b1;
      if (we && addr == 5'h0C) m_mask = m_mask | wdata;
      else if (we && addr == 5'h10) m_mask = m_mask & ~wdata;
      m_irq = exp_irq(m_pend, m_mask);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic post(int q, logic en);
    post_v = 1; post_qid = 7'(q); post_ien = en;
  endtask

  task automatic dbell(int q, logic en, logic drain);
    db_v = 1; db_qid = 7'(q); db_ien = en; tail = 16'd5; head = drain ? 16'd5 : 16'd3;
  endtask

  task automatic wreg(logic [4:0] a, logic [31:0] d);
    we = 1; addr = a; wdata = d;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", 32'(irq), 0);
    addr = 5'h0C; #1 chk("R1 mask@0C", rdata, 0);
    addr = 5'h10; #1 chk("R1 mask@10", rdata, 0);

    post(3, 1);
    #1 chk("R12 no comb path", 32'(irq), 0);
    cyc(); chk("R2 post sets", 32'(irq), 1);

    wreg(5'h0C, 32'h8); cyc(); chk("R7 set mask", 32'(irq), 0);
    addr = 5'h0C; #1 chk("R8 rd 0C", rdata, 32'h8);
    addr = 5'h10; #1 chk("R8 rd 10", rdata, 32'h8);
    addr = 5'h08; #1 chk("R8 rd other", rdata, 0);
    wreg(5'h10, 32'hFFFF_FFF0); cyc(); chk("R7 clr other bits", 32'(irq), 0);
    wreg(5'h10, 32'h8); cyc(); chk("R7 clr mask", 32'(irq), 1);

    dbell(3, 1, 0); cyc(); chk("R5 head!=tail", 32'(irq), 1);
    dbell(3, 0, 1); cyc(); chk("R6 disabled db", 32'(irq), 1);
    dbell(3, 1, 1); cyc(); chk("R5 drain clears", 32'(irq), 0);

    post(9, 0); cyc(); chk("R3 disabled post", 32'(irq), 0);
    post(64, 1); cyc(); chk("R4 qid 64", 32'(irq), 0);
    post(100, 1); cyc(); chk("R4 qid 100", 32'(irq), 0);

    wreg(5'h0C, 32'hFFFF_FFFF); cyc();
    post(40, 1); cyc(); chk("R9 upper unmasked", 32'(irq), 1);
    dbell(104, 1, 1); cyc(); chk("R4 db qid 104", 32'(irq), 1);
    dbell(40, 1, 1); cyc(); chk("R5 drain q40", 32'(irq), 0);
    wreg(5'h10, 32'hFFFF_FFFF); cyc();

    msix_en = 1; post(5, 1); cyc(); chk("R10 post frozen", 32'(irq), 0);
    msix_en = 0; cyc(); chk("R10 nothing latched", 32'(irq), 0);
    post(5, 1); cyc(); chk("R2 q5", 32'(irq), 1);
    msix_en = 1; dbell(5, 1, 1); cyc(); chk("R10 db frozen", 32'(irq), 1);
    msix_en = 1; wreg(5'h0C, 32'h20); cyc(); chk("R10 mask wr frozen", 32'(irq), 1);
    addr = 5'h0C; #1 chk("R10 mask unchanged", rdata, 0);
    msix_en = 0; cyc(); chk("R10 pend kept", 32'(irq), 1);
    dbell(5, 1, 1); cyc(); chk("R5 q5 drained", 32'(irq), 0);

    post(7, 1); dbell(7, 1, 1); cyc(); chk("R11 post wins", 32'(irq), 1);
    dbell(7, 1, 1); cyc(); chk("R11 later drain", 32'(irq), 0);

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 100) < 8) msix_en = ~msix_en;
      if (msix_en && ($urandom % 4) == 0) msix_en = 0;
      if (($urandom % 100) < 45) post(int'($urandom % 80), ($urandom % 5) != 0);
      if (($urandom % 100) < 40) begin
        dbell(int'($urandom % 80), ($urandom % 5) != 0, ($urandom % 2) == 0);
        if (($urandom % 4) == 0) db_qid = post_qid;
      end
      if (($urandom % 100) < 15) begin
        case ($urandom % 3)
          0: addr = 5'h0C;
          1: addr = 5'h10;
          default: addr = 5'h08;
        endcase
        we = 1; wdata = $urandom;
        if (($urandom % 2) == 0) wdata = wdata & 32'h0000_00FF;
      end
      cyc();
      chk("R12 random pin", 32'(irq), 32'(m_irq));
      if (addr == 5'h0C || addr == 5'h10) begin
        #1 chk("R8 random rd", rdata, m_mask);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule